// File: doc/BRIEF.md
# Boost Regulator Soft-Start and Fault Sequencer

This block is the digital supervisor of a boost regulator. After an active-low enable is pulled low, it walks the power stage through a fixed power-up ramp. First it pre-charges the output through the input switch acting as a limited current source. Then it closes that switch fully. Finally it lets the switching driver run while the inductor current limit is raised in quarter steps until full scale is reached. Each stage lasts a set number of timebase ticks. The ticks arrive on a single-cycle strobe that nominally runs at 1 MHz, so the default stage lengths are 2.048 ms and 128 µs.

While the ramp runs, and after it reaches normal operation, the block watches four digital fault flags: input undervoltage, input-switch overcurrent, output overvoltage and over-temperature. An overcurrent opens the power path for one clock and restarts the ramp. An overvoltage or over-temperature opens the power path and parks the block in a wait state until the matching recovery flag is seen. An undervoltage also turns the I/Os off, and the block waits for the supply-good flag. Every recovery re-enters the ramp at its first stage.

States: OFF (disabled), INRUSH (pre-charge), SWITCH_ON, BOOST_25, BOOST_50, BOOST_75, NORMAL, RESTART (one-clock power-path break), UV_WAIT, OV_WAIT and OT_WAIT. Transitions:
- OFF→INRUSH when enable is low.
- INRUSH→SWITCH_ON, SWITCH_ON→BOOST_25, BOOST_25→BOOST_50, BOOST_50→BOOST_75 and BOOST_75→NORMAL, each on stage timeout.
- Any running state→RESTART on overcurrent, and RESTART→INRUSH.
- Any running state→UV_WAIT, OV_WAIT or OT_WAIT on the matching fault.
- UV_WAIT, OV_WAIT and OT_WAIT→INRUSH on their recovery flag.
- Any state→OFF whenever enable is high.

Top module: `bsq_sequencer`

## Requirements
- R1: While `en_n_i` is high, the next clock puts the block in OFF, from any state. In OFF all outputs are zero: switch mode 0, driver off, current limit 0, I/O off. The same zero outputs hold during reset.
- R2: With enable low, OFF is followed by INRUSH, SWITCH_ON, BOOST_25, BOOST_50, BOOST_75 and NORMAL, in that order. INRUSH and each BOOST state last `LONG_TICKS` ticks and SWITCH_ON lasts `SHORT_TICKS` ticks. The state advances on the clock that samples the last tick, and clocks without `tick_i` do not count.
- R3: The switch mode encoding is 0 = off, 1 = current source and 2 = fully on. The current-limit encoding is 0 = off, 1 = 25 %, 2 = 50 %, 3 = 75 % and 4 = 100 %. The outputs in each state are:
  - INRUSH: mode 1, driver off, limit 0.
  - SWITCH_ON: mode 2, driver off, limit 0.
  - BOOST_25, BOOST_50, BOOST_75: mode 2, driver on, limit 1, 2, 3.
  - NORMAL: mode 2, driver on, limit 4.
  - The I/O enable is 1 in every state except OFF and UV_WAIT.
- R4: NORMAL is held indefinitely while enable stays low and no fault flag is set.
- R5: An overcurrent in a running state, with no higher fault present, gives one clock of RESTART: mode 0, driver off, limit 0, I/O on. INRUSH follows; if the overcurrent is still present, RESTART repeats.
- R6: An overvoltage in a running state moves to OV_WAIT (mode 0, driver off, limit 0, I/O on). The block stays there until `ov_clear_i`, then goes to INRUSH.
- R7: An over-temperature in a running state moves to OT_WAIT (same outputs as OV_WAIT). The block stays there until `ot_clear_i`, then goes to INRUSH.
- R8: An undervoltage in a running state moves to UV_WAIT, where all outputs are zero including the I/O enable. The block stays there until `uv_clear_i`, then goes to INRUSH.
- R9: When several faults are set together, undervoltage wins over overvoltage, overvoltage over over-temperature, and over-temperature over overcurrent.
- R10: In OFF and in the three wait states the fault flags have no effect. In a wait state only its own recovery flag has an effect.
- R11: The stage tick counter clears on every state change. A stage re-entered after a restart therefore runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock timebase strobe (nominally 1 MHz) |
| en_n_i | input | 1 | Active-low enable |
| uv_i | input | 1 | Input supply below the power-off level |
| uv_clear_i | input | 1 | Input supply above the power-on level |
| oc_i | input | 1 | Input-switch overcurrent |
| ov_i | input | 1 | Output overvoltage |
| ov_clear_i | input | 1 | Output back below the overvoltage release level |
| ot_i | input | 1 | Junction over-temperature |
| ot_clear_i | input | 1 | Junction below the turn-on temperature |
| sw_mode_o | output | 2 | Input switch mode: 0 off, 1 current source, 2 fully on |
| drv_en_o | output | 1 | Switching driver enable |
| ilim_o | output | 3 | Current-limit level: 0 off, 1..4 = 25..100 % |
| io_en_o | output | 1 | I/O enable |

## Verification
The assertions take all inputs to be synchronous to `clk`, and `tick_i` to be a single-clock strobe. They also assume nothing about how long a fault or recovery flag stays set, so one-clock pulses are legal. The stimulus changes inputs one time unit after the rising edge and drives ticks every clock or every third clock. Faults are raised both as one-clock pulses and as held levels. Recovery flags are raised both in the wait state they belong to and in other wait states.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [3:0] {
        ST_OFF      = 4'd0,
        ST_INRUSH   = 4'd1,
        ST_SWON     = 4'd2,
        ST_BOOST25  = 4'd3,
        ST_BOOST50  = 4'd4,
        ST_BOOST75  = 4'd5,
        ST_NORMAL   = 4'd6,
        ST_RESTART  = 4'd7,
        ST_UV_WAIT  = 4'd8,
        ST_OV_WAIT  = 4'd9,
        ST_OT_WAIT  = 4'd10
    } seq_state_e;

    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_SRC  = 2'd1,
        SW_FULL = 2'd2
    } sw_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UV   = 3'd1,
        FLT_OV   = 3'd2,
        FLT_OT   = 3'd3,
        FLT_OC   = 3'd4
    } fault_e;

    localparam logic [2:0] ILIM_OFF = 3'd0;
    localparam logic [2:0] ILIM_25  = 3'd1;
    localparam logic [2:0] ILIM_50  = 3'd2;
    localparam logic [2:0] ILIM_75  = 3'd3;
    localparam logic [2:0] ILIM_100 = 3'd4;

    function automatic logic is_running(input seq_state_e s);
        return (s == ST_INRUSH)  || (s == ST_SWON)    ||
               (s == ST_BOOST25) || (s == ST_BOOST50) ||
               (s == ST_BOOST75) || (s == ST_NORMAL)  ||
               (s == ST_RESTART);
    endfunction

endpackage

// File: rtl/bsq_stage_timer.sv
module bsq_stage_timer #(
    parameter int LONG_TICKS  = 2048,
    parameter int SHORT_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    input  logic short_sel_i,
    output logic done_o
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(MAX_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last   = short_sel_i ? SHORT_LAST : LONG_LAST;
    assign done_o = tick_i && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_SAT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11: a state change leaves the counter at zero
    assert_clear_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/bsq_fault_arbiter.sv
module bsq_fault_arbiter
    import bsq_pkg::*;
(
    input  logic   uv_i,
    input  logic   ov_i,
    input  logic   ot_i,
    input  logic   oc_i,
    output fault_e fault_o
);
    always_comb begin
        if (uv_i)      fault_o = FLT_UV;
        else if (ov_i) fault_o = FLT_OV;
        else if (ot_i) fault_o = FLT_OT;
        else if (oc_i) fault_o = FLT_OC;
        else           fault_o = FLT_NONE;
    end

    // R9: undervoltage always dominates the other flags
    assert_uv_first_R9: assert final (!uv_i || (fault_o == FLT_UV));

endmodule

// File: rtl/bsq_output_map.sv
module bsq_output_map
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_i,
    output logic [1:0] sw_mode_o,
    output logic       drv_en_o,
    output logic [2:0] ilim_o,
    output logic       io_en_o
);
    always_comb begin
        sw_mode_o = SW_OFF;
        drv_en_o  = 1'b0;
        ilim_o    = ILIM_OFF;
        io_en_o   = 1'b1;
        unique case (state_i)
            ST_OFF:      io_en_o = 1'b0;
            ST_UV_WAIT:  io_en_o = 1'b0;
            ST_INRUSH:   sw_mode_o = SW_SRC;
            ST_SWON:     sw_mode_o = SW_FULL;
            ST_BOOST25: begin
                sw_mode_o = SW_FULL;
                drv_en_o  = 1'b1;
                ilim_o    = ILIM_25;
            end
            ST_BOOST50: begin
                sw_mode_o = SW_FULL;
                drv_en_o  = 1'b1;
                ilim_o    = ILIM_50;
            end
            ST_BOOST75: begin
                sw_mode_o = SW_FULL;
                drv_en_o  = 1'b1;
                ilim_o    = ILIM_75;
            end
            ST_NORMAL: begin
                sw_mode_o = SW_FULL;
                drv_en_o  = 1'b1;
                ilim_o    = ILIM_100;
            end
            ST_RESTART, ST_OV_WAIT, ST_OT_WAIT: begin
                sw_mode_o = SW_OFF;
            end
            default: io_en_o = 1'b0;
        endcase
    end

    // R3: the driver never runs unless the input switch is fully closed
    assert_drv_needs_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (sw_mode_o == SW_FULL));

endmodule

// File: rtl/bsq_sequencer.sv
module bsq_sequencer
    import bsq_pkg::*;
#(
    parameter int LONG_TICKS  = 2048,
    parameter int SHORT_TICKS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       en_n_i,
    input  logic       uv_i,
    input  logic       uv_clear_i,
    input  logic       oc_i,
    input  logic       ov_i,
    input  logic       ov_clear_i,
    input  logic       ot_i,
    input  logic       ot_clear_i,
    output logic [1:0] sw_mode_o,
    output logic       drv_en_o,
    output logic [2:0] ilim_o,
    output logic       io_en_o
);
    seq_state_e st_q, st_d, run_next;
    fault_e     fault;
    logic       stage_done;
    logic       state_change;

    assign state_change = (st_d != st_q);

    bsq_stage_timer #(
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .clear_i    (state_change),
        .short_sel_i(st_q == ST_SWON),
        .done_o     (stage_done)
    );

    bsq_fault_arbiter arb_i (
        .uv_i   (uv_i),
        .ov_i   (ov_i),
        .ot_i   (ot_i),
        .oc_i   (oc_i),
        .fault_o(fault)
    );

    // next state of a running state: faults first, then the ramp
    always_comb begin
        run_next = st_q;
        unique case (fault)
            FLT_UV: run_next = ST_UV_WAIT;
            FLT_OV: run_next = ST_OV_WAIT;
            FLT_OT: run_next = ST_OT_WAIT;
            FLT_OC: run_next = ST_RESTART;
            FLT_NONE: begin
                unique case (st_q)
                    ST_INRUSH:  if (stage_done) run_next = ST_SWON;
                    ST_SWON:    if (stage_done) run_next = ST_BOOST25;
                    ST_BOOST25: if (stage_done) run_next = ST_BOOST50;
                    ST_BOOST50: if (stage_done) run_next = ST_BOOST75;
                    ST_BOOST75: if (stage_done) run_next = ST_NORMAL;
                    ST_RESTART: run_next = ST_INRUSH;
                    default:    run_next = st_q;
                endcase
            end
            default: run_next = st_q;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (en_n_i) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:     st_d = ST_INRUSH;
                ST_UV_WAIT: if (uv_clear_i) st_d = ST_INRUSH;
                ST_OV_WAIT: if (ov_clear_i) st_d = ST_INRUSH;
                ST_OT_WAIT: if (ot_clear_i) st_d = ST_INRUSH;
                ST_INRUSH, ST_SWON, ST_BOOST25, ST_BOOST50,
                ST_BOOST75, ST_NORMAL, ST_RESTART:
                            st_d = run_next;
                default:    st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    bsq_output_map map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (st_q),
        .sw_mode_o(sw_mode_o),
        .drv_en_o (drv_en_o),
        .ilim_o   (ilim_o),
        .io_en_o  (io_en_o)
    );

    // R1: a high enable pin shuts everything down on the next clock
    assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_i |=> (sw_mode_o == 2'd0 && !drv_en_o && ilim_o == 3'd0 && !io_en_o));

    // R3: the current limit only steps up one level at a time or drops to zero
    assert_ilim_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_o != 3'd0) |-> (ilim_o == $past(ilim_o) || ilim_o == $past(ilim_o) + 3'd1));

    // R4: NORMAL holds with no fault and enable low
    assert_normal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && !en_n_i && !uv_i && !ov_i && !ot_i && !oc_i) |=> (st_q == ST_NORMAL));

    // R5: a lone overcurrent opens the power path on the next clock
    assert_oc_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_running(st_q) && !en_n_i && oc_i && !uv_i && !ov_i && !ot_i)
        |=> (sw_mode_o == 2'd0 && !drv_en_o && io_en_o));

    // R6: the overvoltage wait persists until its recovery flag
    assert_ov_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OV_WAIT && !en_n_i && !ov_clear_i) |=> (st_q == ST_OV_WAIT));

    // R7: the over-temperature wait persists until its recovery flag
    assert_ot_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OT_WAIT && !en_n_i && !ot_clear_i) |=> (st_q == ST_OT_WAIT));

    // R8: an undervoltage in a running state drops the I/O enable
    assert_uv_io_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_running(st_q) && !en_n_i && uv_i) |=> !io_en_o);

    // R10: with enable low, OFF always proceeds to INRUSH whatever the faults
    assert_off_ignores_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !en_n_i) |=> (sw_mode_o == 2'd1));

endmodule

// File: tb/bsq_sequencer_tb_top.sv
`timescale 1ns/100ps
module bsq_sequencer_tb_top;
    localparam int LONG  = 16;
    localparam int SHORT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic en_n_i = 1'b1;
    logic uv_i = 1'b0, uv_clear_i = 1'b0, oc_i = 1'b0;
    logic ov_i = 1'b0, ov_clear_i = 1'b0, ot_i = 1'b0, ot_clear_i = 1'b0;
    logic [1:0] sw_mode_o;
    logic       drv_en_o;
    logic [2:0] ilim_o;
    logic       io_en_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int tick_mode = 1;
    int tick_cnt = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    bsq_sequencer #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_n_i(en_n_i),
        .uv_i(uv_i), .uv_clear_i(uv_clear_i), .oc_i(oc_i),
        .ov_i(ov_i), .ov_clear_i(ov_clear_i), .ot_i(ot_i), .ot_clear_i(ot_clear_i),
        .sw_mode_o(sw_mode_o), .drv_en_o(drv_en_o), .ilim_o(ilim_o), .io_en_o(io_en_o)
    );

    // reference model: 0 off, 1 inrush, 2 switch on, 3..5 boost, 6 normal,
    // 7 restart, 8 uv wait, 9 ov wait, 10 ot wait
    int m_st = 0;
    int m_cnt = 0;

    function automatic int stage_len(input int s);
        return (s == 2) ? SHORT : LONG;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  <= 0;
            m_cnt <= 0;
        end else begin
            int ns;
            ns = m_st;
            if (en_n_i) ns = 0;
            else if (m_st == 0) ns = 1;
            else if (m_st == 8) begin if (uv_clear_i) ns = 1; end
            else if (m_st == 9) begin if (ov_clear_i) ns = 1; end
            else if (m_st == 10) begin if (ot_clear_i) ns = 1; end
            else if (uv_i) ns = 8;
            else if (ov_i) ns = 9;
            else if (ot_i) ns = 10;
            else if (oc_i) ns = 7;
            else if (m_st == 7) ns = 1;
            else if (m_st >= 1 && m_st <= 5 && tick_i && m_cnt == stage_len(m_st) - 1) ns = m_st + 1;
            if (ns != m_st) m_cnt <= 0;
            else if (tick_i) m_cnt <= m_cnt + 1;
            m_st <= ns;
        end
    end

    function automatic logic [6:0] expect_out(input int s);
        // {io, sw[1:0], drv, ilim[2:0]}
        case (s)
            1:  return {1'b1, 2'd1, 1'b0, 3'd0};
            2:  return {1'b1, 2'd2, 1'b0, 3'd0};
            3:  return {1'b1, 2'd2, 1'b1, 3'd1};
            4:  return {1'b1, 2'd2, 1'b1, 3'd2};
            5:  return {1'b1, 2'd2, 1'b1, 3'd3};
            6:  return {1'b1, 2'd2, 1'b1, 3'd4};
            7, 9, 10: return {1'b1, 2'd0, 1'b0, 3'd0};
            default: return 7'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        logic [6:0] act, exp_v;
        act   = {io_en_o, sw_mode_o, drv_en_o, ilim_o};
        exp_v = expect_out(m_st);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s t=%0t state=%0d actual=%b expected=%b", cur_req, $time, m_st, act, exp_v);
        end
    end

    always @(posedge clk) begin
        #1;
        tick_cnt = tick_cnt + 1;
        if (tick_mode == 0) tick_i = 1'b0;
        else if (tick_cnt >= tick_mode) begin
            tick_i = 1'b1;
            tick_cnt = 0;
        end else tick_i = 1'b0;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_state(input int s);
        while (m_st != s) wait_cycles(1);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        cur_req = "R1";
        wait_cycles(5);

        cur_req = "R2";
        en_n_i = 1'b0;
        wait_state(6);
        cur_req = "R4";
        wait_cycles(40);

        cur_req = "R1";
        en_n_i = 1'b1;
        wait_cycles(3);
        en_n_i = 1'b0;
        tick_mode = 3;
        cur_req = "R2";
        wait_state(4);
        wait_cycles(7);
        cur_req = "R5";
        oc_i = 1'b1;
        wait_cycles(1);
        oc_i = 1'b0;
        cur_req = "R11";
        wait_state(1);
        wait_state(3);

        cur_req = "R3";
        tick_mode = 1;
        wait_state(6);
        cur_req = "R9";
        ov_i = 1'b1; oc_i = 1'b1; ot_i = 1'b1;
        wait_cycles(1);
        oc_i = 1'b0; ot_i = 1'b0;
        cur_req = "R10";
        wait_cycles(5);
        uv_i = 1'b1; oc_i = 1'b1; ot_clear_i = 1'b1; uv_clear_i = 1'b1;
        wait_cycles(5);
        uv_i = 1'b0; oc_i = 1'b0; ot_clear_i = 1'b0; uv_clear_i = 1'b0;
        cur_req = "R6";
        wait_cycles(3);
        ov_i = 1'b0;
        wait_cycles(2);
        ov_clear_i = 1'b1;
        wait_cycles(1);
        ov_clear_i = 1'b0;
        wait_state(3);

        cur_req = "R7";
        ot_i = 1'b1;
        wait_cycles(2);
        ot_i = 1'b0;
        wait_cycles(4);
        ov_clear_i = 1'b1;
        wait_cycles(2);
        ov_clear_i = 1'b0;
        ot_clear_i = 1'b1;
        wait_cycles(1);
        ot_clear_i = 1'b0;
        wait_state(6);

        cur_req = "R9";
        uv_i = 1'b1; ov_i = 1'b1;
        wait_cycles(1);
        ov_i = 1'b0;
        cur_req = "R8";
        wait_cycles(4);
        uv_i = 1'b0;
        wait_cycles(3);
        uv_clear_i = 1'b1;
        wait_cycles(1);
        uv_clear_i = 1'b0;
        wait_state(2);

        cur_req = "R5";
        oc_i = 1'b1;
        wait_cycles(4);
        oc_i = 1'b0;
        wait_state(2);

        cur_req = "R10";
        en_n_i = 1'b1;
        wait_cycles(2);
        uv_i = 1'b1; ov_i = 1'b1; oc_i = 1'b1; ot_i = 1'b1;
        wait_cycles(3);
        uv_i = 1'b0; ov_i = 1'b0; oc_i = 1'b0; ot_i = 1'b0;
        en_n_i = 1'b0;
        wait_state(6);

        cur_req = "R1";
        ov_i = 1'b1;
        wait_cycles(1);
        ov_i = 1'b0;
        wait_cycles(2);
        en_n_i = 1'b1;
        wait_cycles(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule